// File: doc/BRIEF.md
# Texture-Rejecting Corner Validity Filter

This block sits after a corner-response stage in a streaming vision pipeline. For each pixel it receives a square neighbourhood of corner-response values, all at once, with the pixel under test in the middle. It then decides whether a strong response there belongs to a real geometric structure or to isolated texture. A true corner is expected to keep a similar response pattern as one moves outward along its diagonals. Speckled foliage and other fine texture does not.

The filter reads three nested rings of diagonal samples around the centre. It sums the absolute differences between the inner and middle rings, and between the middle and outer rings. The two sums together form a texture score. The pixel is accepted only when that score lies strictly below a threshold supplied at run time. One window enters per clock. The accept flag leaves a fixed number of cycles later, together with a valid strobe. Any stage that consumes candidate corners can AND this flag with its own detection result.

Top module: `texture_gate`

## Requirements
- R1: While rst_n is low, ok_valid_o and ok_flag_o are both 0.
- R2: Window element (row, col) occupies win_i bits [(row*9+col)*16 +: 16], and the centre is (4,4). Ring k (k = 1, 2, 3) is the four samples at row 4±(k+1), col 4±(k+1). Samples of adjacent rings are paired when they lie on the same diagonal direction.
- R3: The texture score is the sum, over the four diagonal directions, of |ring1 − ring2| + |ring2 − ring3|. It is computed on unsigned values at full width, so the largest possible score, 524280, is exact.
- R4: For a valid window, ok_flag_o is 1 exactly when the score is strictly less than thresh_i. Equality rejects the pixel, and a threshold of 0 rejects every pixel.
- R5: ok_valid_o repeats win_valid_i three clock cycles later. The threshold used for a result is the one presented in the same cycle as its window, even if thresh_i changes on every cycle.
- R6: When the window is not valid, ok_flag_o is 0 whatever the window and threshold hold.
- R7: Samples outside the twelve ring positions have no effect on the result. This includes the centre, the row and column through the centre, and the off-diagonal positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_valid_i | input | 1 | Window on win_i is valid this cycle |
| win_i | input | 1296 | 9x9 corner-response window, 16 bits per sample, row-major |
| thresh_i | input | 19 | Texture threshold; accept when score is below it |
| ok_valid_o | output | 1 | Result valid, three cycles after win_valid_i |
| ok_flag_o | output | 1 | 1 when the pixel is accepted as a non-textured corner |

## Verification
The bench places a single non-zero sample at each of the twelve ring positions in turn. It sets the threshold one above and exactly at the expected score. A design with a wrong tap index or a misaligned ring pairing gives the wrong flag at one of these two thresholds, and a `<=` comparison accepts at equality. Alternating inner and outer rings at full scale against a zero middle ring give the maximum score, which exposes a partial or total sum that is one bit too narrow. Large values placed everywhere off the rings expose taps wired to the wrong positions. Thresholds that change on every cycle, interleaved with invalid windows, expose a threshold that is not delayed with its data, a valid strobe off by a cycle, and a flag that is not gated by valid.

// File: rtl/tex_pkg.sv
package tex_pkg;

    // Number of diagonal directions sampled per ring.
    localparam int NCORN = 4;

    // Flat element index of a diagonal tap.
    // corner bit 1 selects the row sign, corner bit 0 the column sign (1 = positive).
    function automatic int tap_index(input int win, input int off, input int corner);
        int ctr;
        int sy;
        int sx;
        ctr = (win - 1) / 2;
        sy  = ((corner & 2) != 0) ? 1 : -1;
        sx  = ((corner & 1) != 0) ? 1 : -1;
        return (ctr + sy * off) * win + (ctr + sx * off);
    endfunction

endpackage

// File: rtl/tex_diff_stage.sv
module tex_diff_stage #(
    parameter int RESP_W  = 16,
    parameter int NPAIR   = 2,
    parameter int NCORN   = 4,
    parameter int SCORE_W = 19
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    valid_i,
    input  logic [SCORE_W-1:0]                      thr_i,
    input  logic [NPAIR:0][NCORN-1:0][RESP_W-1:0]   taps_i,
    output logic                                    valid_o,
    output logic [SCORE_W-1:0]                      thr_o,
    output logic [NPAIR-1:0][NCORN-1:0][RESP_W-1:0] diff_o
);

    typedef struct packed {
        logic                                    vld;
        logic [SCORE_W-1:0]                      thr;
        logic [NPAIR-1:0][NCORN-1:0][RESP_W-1:0] diff;
    } diff_st_t;

    diff_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        st_d.thr = thr_i;
        for (int p = 0; p < NPAIR; p++) begin
            for (int c = 0; c < NCORN; c++) begin
                if (taps_i[p][c] > taps_i[p+1][c])
                    st_d.diff[p][c] = taps_i[p][c] - taps_i[p+1][c];
                else
                    st_d.diff[p][c] = taps_i[p+1][c] - taps_i[p][c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.vld;
    assign thr_o   = st_q.thr;
    assign diff_o  = st_q.diff;

endmodule

// File: rtl/tex_part_stage.sv
module tex_part_stage #(
    parameter int RESP_W  = 16,
    parameter int NPAIR   = 2,
    parameter int NCORN   = 4,
    parameter int PART_W  = 18,
    parameter int SCORE_W = 19
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    valid_i,
    input  logic [SCORE_W-1:0]                      thr_i,
    input  logic [NPAIR-1:0][NCORN-1:0][RESP_W-1:0] diff_i,
    output logic                                    valid_o,
    output logic [SCORE_W-1:0]                      thr_o,
    output logic [NPAIR-1:0][PART_W-1:0]            part_o
);

    typedef struct packed {
        logic                         vld;
        logic [SCORE_W-1:0]           thr;
        logic [NPAIR-1:0][PART_W-1:0] part;
    } part_st_t;

    part_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        st_d.thr = thr_i;
        for (int p = 0; p < NPAIR; p++) begin
            st_d.part[p] = '0;
            for (int c = 0; c < NCORN; c++)
                st_d.part[p] = st_d.part[p] + PART_W'(diff_i[p][c]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.vld;
    assign thr_o   = st_q.thr;
    assign part_o  = st_q.part;

endmodule

// File: rtl/tex_judge_stage.sv
module tex_judge_stage #(
    parameter int NPAIR   = 2,
    parameter int PART_W  = 18,
    parameter int SCORE_W = 19
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         valid_i,
    input  logic [SCORE_W-1:0]           thr_i,
    input  logic [NPAIR-1:0][PART_W-1:0] part_i,
    output logic                         valid_o,
    output logic                         flag_o
);

    typedef struct packed {
        logic vld;
        logic flag;
    } judge_st_t;

    judge_st_t          st_d, st_q;
    logic [SCORE_W-1:0] score;

    always_comb begin
        score = '0;
        for (int p = 0; p < NPAIR; p++)
            score = score + SCORE_W'(part_i[p]);
        st_d      = st_q;
        st_d.vld  = valid_i;
        st_d.flag = valid_i && (score < thr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.vld;
    assign flag_o  = st_q.flag;

endmodule

// File: rtl/texture_gate.sv
module texture_gate #(
    parameter  int RESP_W    = 16,
    parameter  int WIN       = 9,
    parameter  int RING_BASE = 2,
    parameter  int NRING     = 3,
    localparam int NPAIR     = NRING - 1,
    localparam int PART_W    = RESP_W + $clog2(tex_pkg::NCORN),
    localparam int SCORE_W   = PART_W + $clog2(NPAIR)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       win_valid_i,
    input  logic [WIN*WIN*RESP_W-1:0]  win_i,
    input  logic [SCORE_W-1:0]         thresh_i,
    output logic                       ok_valid_o,
    output logic                       ok_flag_o
);

    localparam int NCORN = tex_pkg::NCORN;

    logic [NPAIR:0][NCORN-1:0][RESP_W-1:0]   taps;
    logic [NPAIR-1:0][NCORN-1:0][RESP_W-1:0] diff;
    logic [NPAIR-1:0][PART_W-1:0]            part;
    logic                                    s1_vld, s2_vld;
    logic [SCORE_W-1:0]                      s1_thr, s2_thr;

    // Outermost ring must fit inside the window.
    initial begin
        if (RING_BASE + NRING - 1 > (WIN - 1) / 2)
            $error("ring offsets exceed the window");
    end

    for (genvar r = 0; r < NRING; r++) begin : g_ring
        for (genvar c = 0; c < NCORN; c++) begin : g_corn
            localparam int IDX = tex_pkg::tap_index(WIN, RING_BASE + r, c);
            assign taps[r][c] = win_i[IDX*RESP_W +: RESP_W];
        end
    end

    tex_diff_stage #(
        .RESP_W(RESP_W), .NPAIR(NPAIR), .NCORN(NCORN), .SCORE_W(SCORE_W)
    ) u_diff (
        .clk(clk), .rst_n(rst_n),
        .valid_i(win_valid_i), .thr_i(thresh_i), .taps_i(taps),
        .valid_o(s1_vld), .thr_o(s1_thr), .diff_o(diff)
    );

    tex_part_stage #(
        .RESP_W(RESP_W), .NPAIR(NPAIR), .NCORN(NCORN),
        .PART_W(PART_W), .SCORE_W(SCORE_W)
    ) u_part (
        .clk(clk), .rst_n(rst_n),
        .valid_i(s1_vld), .thr_i(s1_thr), .diff_i(diff),
        .valid_o(s2_vld), .thr_o(s2_thr), .part_o(part)
    );

    tex_judge_stage #(
        .NPAIR(NPAIR), .PART_W(PART_W), .SCORE_W(SCORE_W)
    ) u_judge (
        .clk(clk), .rst_n(rst_n),
        .valid_i(s2_vld), .thr_i(s2_thr), .part_i(part),
        .valid_o(ok_valid_o), .flag_o(ok_flag_o)
    );

endmodule

// File: rtl/tex_gate_chk.sv
module tex_gate_chk #(
    parameter int SCORE_W = 19
) (
    input logic               clk,
    input logic               rst_n,
    input logic               win_valid_i,
    input logic [SCORE_W-1:0] thresh_i,
    input logic               ok_valid_o,
    input logic               ok_flag_o
);

    // Edges seen since reset, saturating at the pipeline depth.
    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!ok_valid_o && !ok_flag_o)
                else $error("outputs active during reset");
        end
    end

    a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3) |-> (ok_valid_o == $past(win_valid_i, 3)));

    a_r6_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ok_flag_o |-> ok_valid_o);

    a_r4_zero_thresh_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q == 2'd3) && ($past(thresh_i, 3) == '0)) |-> !ok_flag_o);

    a_r3_full_thresh_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q == 2'd3) && $past(win_valid_i, 3)
            && ($past(thresh_i, 3) == {SCORE_W{1'b1}})) |-> ok_flag_o);

endmodule

bind texture_gate tex_gate_chk #(.SCORE_W(SCORE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .win_valid_i(win_valid_i), .thresh_i(thresh_i),
    .ok_valid_o(ok_valid_o), .ok_flag_o(ok_flag_o)
);

// File: tb/sim_texture_gate.sv
module sim_texture_gate;

    localparam int W  = 9;
    localparam int RW = 16;
    localparam int SW = 19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              win_valid = 1'b0;
    logic [W*W*RW-1:0] win_bus = '0;
    logic [SW-1:0]     thresh = '0;
    logic              ok_valid, ok_flag;

    logic [W*W*RW-1:0] win_r;
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    bit ev_q[$];
    bit ef_q[$];
    int tag_q[$];

    always #5 clk = ~clk;

    texture_gate u0 (
        .clk(clk), .rst_n(rst_n), .win_valid_i(win_valid), .win_i(win_bus),
        .thresh_i(thresh), .ok_valid_o(ok_valid), .ok_flag_o(ok_flag)
    );

    function automatic int pix(input int r, input int c);
        return int'(win_r[(r*W+c)*RW +: RW]);
    endfunction

    task automatic put(input int r, input int c, input int v);
        win_r[(r*W+c)*RW +: RW] = v[RW-1:0];
    endtask

    // Reference score: walk each diagonal direction outward from the centre.
    function automatic int ref_score();
        int s = 0;
        for (int dy = -1; dy <= 1; dy += 2) begin
            for (int dx = -1; dx <= 1; dx += 2) begin
                int prev = pix(4 + 2*dy, 4 + 2*dx);
                for (int d = 3; d <= 4; d++) begin
                    int cur = pix(4 + d*dy, 4 + d*dx);
                    s += (prev > cur) ? prev - cur : cur - prev;
                    prev = cur;
                end
            end
        end
        return s;
    endfunction

    task automatic check_out();
        bit v, f;
        int t;
        v = ev_q.pop_front();
        f = ef_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (ok_valid !== v || ok_flag !== f) begin
            bad++;
            $display("FAIL R%0d: valid/flag actual=%b/%b expected=%b/%b at %0t",
                     t, ok_valid, ok_flag, v, f, $time);
        end
    endtask

    task automatic drive(input bit v, input int thr, input int req);
        int sc;
        @(negedge clk);
        check_out();
        win_valid = v;
        win_bus   = win_r;
        thresh    = thr[SW-1:0];
        sc = ref_score();
        ev_q.push_back(v);
        ef_q.push_back(v && (sc < thr));
        tag_q.push_back(req);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int tr [12][2];
        int k;
        win_r = '0;
        // R1: outputs quiet during reset, even with active-looking inputs
        win_valid = 1'b1;
        win_bus   = '1;
        thresh    = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (ok_valid !== 1'b0 || ok_flag !== 1'b0) begin
            bad++;
            $display("FAIL R1: valid/flag actual=%b/%b expected=0/0", ok_valid, ok_flag);
        end
        win_valid = 1'b0;
        win_bus   = '0;
        thresh    = '0;
        rst_n     = 1'b1;
        for (int i = 0; i < 3; i++) begin
            ev_q.push_back(1'b0);
            ef_q.push_back(1'b0);
            tag_q.push_back(5);
        end

        // R2: each ring position alone, threshold just above and at the score
        k = 0;
        for (int d = 2; d <= 4; d++)
            for (int sy = -1; sy <= 1; sy += 2)
                for (int sx = -1; sx <= 1; sx += 2) begin
                    tr[k][0] = 4 + sy*d;
                    tr[k][1] = 4 + sx*d;
                    k++;
                end
        for (int i = 0; i < 12; i++) begin
            int expv;
            win_r = '0;
            put(tr[i][0], tr[i][1], 1000 + i);
            expv = ((i >= 4) && (i < 8)) ? 2*(1000 + i) : (1000 + i);
            drive(1'b1, expv + 1, 2);
            drive(1'b1, expv, 2);
        end

        // R7: everything off the rings at full scale, score stays 0
        win_r = '1;
        for (int d = 2; d <= 4; d++)
            for (int sy = -1; sy <= 1; sy += 2)
                for (int sx = -1; sx <= 1; sx += 2)
                    put(4 + sy*d, 4 + sx*d, 0);
        drive(1'b1, 1, 7);
        drive(1'b1, 0, 7);

        // R3: maximum score, inner and outer at full scale, middle zero
        win_r = '0;
        for (int sy = -1; sy <= 1; sy += 2)
            for (int sx = -1; sx <= 1; sx += 2) begin
                put(4 + 2*sy, 4 + 2*sx, 65535);
                put(4 + 4*sy, 4 + 4*sx, 65535);
            end
        drive(1'b1, 524281, 3);
        drive(1'b1, 524280, 3);
        drive(1'b1, 524287, 3);

        // R4: zero threshold rejects a flat window
        win_r = '0;
        drive(1'b1, 0, 4);
        drive(1'b1, 1, 4);

        // R6: invalid windows with a generous threshold never flag
        drive(1'b0, 524287, 6);
        win_r = '1;
        drive(1'b0, 524287, 6);

        // R5: threshold toggling each cycle against one fixed window, with gaps
        win_r = '0;
        put(2, 2, 500);
        for (int i = 0; i < 8; i++)
            drive((i % 3) != 2, (i % 2 == 0) ? 501 : 500, 5);

        // R3/R4: random windows with thresholds around the score
        for (int i = 0; i < 400; i++) begin
            int sc;
            int thr;
            for (int e = 0; e < W*W; e++)
                win_r[e*RW +: RW] = RW'($urandom);
            if (i % 4 == 0)
                for (int sy = -1; sy <= 1; sy += 2)
                    for (int sx = -1; sx <= 1; sx += 2)
                        for (int d = 2; d <= 4; d++)
                            put(4 + sy*d, 4 + sx*d, 3000 + int'($urandom % 40));
            sc  = ref_score();
            thr = sc + int'($urandom % 3) - 1;
            if (thr < 0) thr = 0;
            drive(($urandom % 8) != 0, thr, (i % 2 == 0) ? 3 : 4);
        end

        win_r = '0;
        for (int i = 0; i < 3; i++) drive(1'b0, 0, 5);
        @(negedge clk);
        check_out();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule